// File: doc/BRIEF.md
# I2C Bus Listener and Event Decoder

This block sits beside a two-wire I2C bus and only listens to it. Both lines come in as plain inputs. Each line passes through a two-flop synchroniser and then an odd-length majority filter. The filtered levels drive a frame decoder, which recognises bus conditions and rebuilds every nine-bit frame. The decoder writes each result as an event into a small FIFO, and a consumer drains that FIFO through a valid/ready port at its own pace.

Every event carries a 3-bit kind and an 8-bit payload. Start, repeated-start and stop events use the payload to report whether a frame was cut short and, if so, how many of its bits had arrived. The first byte after any start is reported as an address. It is tagged as the opening byte of a 10-bit address when its top five bits are 11110. Later bytes are data. Each ninth bit gives an acknowledge or a not-acknowledge event, and the not-acknowledge kind is the block's error flag for a missing acknowledgement. A slave may hold SCL low for as long as it likes: the decoder waits for the next edge and has no timeout.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After reset is released, `evt_valid` is low until the bus produces an event.
- R2: A falling SDA while SCL stays high, seen while no transfer is open, gives kind 0 (start) with payload 0x00.
- R3: A start condition seen while a transfer is open gives kind 1 (repeated start). The payload holds the number of bits committed in the current frame in bits 3:0, and bit 7 is set when that number is not zero. No partial byte is reported.
- R4: A rising SDA while SCL stays high gives kind 2 (stop), with the same payload rule as R3, and closes the transfer.
- R5: The first byte after a start or repeated start is reported MSB first, with the address in bits 7:1 and the direction bit in bit 0. It uses kind 4 when bits 7:3 are 11110, and kind 3 otherwise.
- R6: Every later byte in the transfer is reported as kind 5 with the byte as payload.
- R7: The ninth bit of each frame gives kind 6 when SDA is low (acknowledge) or kind 7 when SDA is high (not-acknowledge, the error kind), both with payload 0x00.
- R8: A bit is sampled when SCL rises and committed when SCL falls. SCL may be held low for any number of cycles without losing bit alignment.
- R9: A pulse lasting one system clock on SCL or SDA has no effect on the decoded events.
- R10: SCL activity while no transfer is open produces no event.
- R11: Events leave in arrival order. Up to `FIFO_DEPTH` of them are held while `evt_ready` is low, and the head stays stable while `evt_valid` is high and `evt_ready` is low.
- R12: Start and stop are recognised only when SCL was high both before and after the SDA edge. SDA changes while SCL is low are data and give no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| evt_valid | output | 1 | An event is present at the head of the FIFO |
| evt_ready | input | 1 | Consumer accepts the head event |
| evt_type | output | 3 | Event kind (codes as in R2 to R7) |
| evt_data | output | 8 | Event payload |

## Verification
The hardest cases to reach are the cut-short frames. A repeated start or stop has to land mid-frame, and the SCL rise that comes before the start or stop must not be counted as a bit. The bench drives bus waveforms at bit level, so it can place a restart after three committed bits, or after a whole byte just before the acknowledge slot, or a stop after five bits, and check the bit count in each payload. Single-clock spikes on either line and a long hold of SCL low in the middle of a byte check that the filter and the edge-driven decoder keep their alignment.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

    typedef enum logic [2:0] {
        EV_START   = 3'd0,
        EV_RESTART = 3'd1,
        EV_STOP    = 3'd2,
        EV_ADDR7   = 3'd3,
        EV_ADDR10  = 3'd4,
        EV_DATA    = 3'd5,
        EV_ACK     = 3'd6,
        EV_NAK     = 3'd7
    } evt_kind_e;

    typedef struct packed {
        evt_kind_e  kind;
        logic [7:0] data;
    } evt_t;

    localparam int unsigned FRAME_BITS = 9;
    localparam logic [4:0]  TEN_BIT_PREFIX = 5'b11110;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int unsigned FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);

    localparam int unsigned HALF = FILT_LEN / 2;

    typedef struct packed {
        logic [1:0]          sync;
        logic [FILT_LEN-1:0] hist;
        logic                out;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.sync = {flt_q.sync[0], line_in};
        flt_d.hist = {flt_q.hist[FILT_LEN-2:0], flt_q.sync[1]};
        flt_d.out  = ($countones(flt_q.hist) > HALF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '1;
        else        flt_q <= flt_d;
    end

    assign line_out = flt_q.out;

endmodule

// File: rtl/i2c_frame_decoder.sv
module i2c_frame_decoder
    import i2c_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic push_o,
    output evt_t evt_o
);

    localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_DBIT = CNT_W'(FRAME_BITS - 2);

    typedef struct packed {
        logic             scl_p;
        logic             sda_p;
        logic             busy;
        logic             first;
        logic             armed;
        logic             samp;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       sh;
        logic             push;
        evt_t             evt;
    } dec_t;

    dec_t dec_d, dec_q;
    logic [7:0] cut_pl;
    logic [7:0] nxt_sh;
    logic       cond_hi;

    always_comb begin
        dec_d       = dec_q;
        dec_d.scl_p = scl;
        dec_d.sda_p = sda;
        dec_d.push  = 1'b0;
        cond_hi     = scl && dec_q.scl_p;
        cut_pl      = {(dec_q.cnt != '0), 3'b000, 4'(dec_q.cnt)};
        nxt_sh      = {dec_q.sh[6:0], dec_q.samp};

        if (cond_hi && dec_q.sda_p && !sda) begin
            dec_d.push      = 1'b1;
            dec_d.evt.kind  = dec_q.busy ? EV_RESTART : EV_START;
            dec_d.evt.data  = cut_pl;
            dec_d.busy      = 1'b1;
            dec_d.first     = 1'b1;
            dec_d.cnt       = '0;
            dec_d.armed     = 1'b0;
        end else if (cond_hi && !dec_q.sda_p && sda) begin
            dec_d.push      = 1'b1;
            dec_d.evt.kind  = EV_STOP;
            dec_d.evt.data  = cut_pl;
            dec_d.busy      = 1'b0;
            dec_d.first     = 1'b0;
            dec_d.cnt       = '0;
            dec_d.armed     = 1'b0;
        end else if (scl && !dec_q.scl_p && dec_q.busy) begin
            dec_d.armed = 1'b1;
            dec_d.samp  = sda;
        end else if (!scl && dec_q.scl_p && dec_q.armed) begin
            dec_d.armed = 1'b0;
            if (dec_q.cnt == ACK_SLOT) begin
                dec_d.push     = 1'b1;
                dec_d.evt.kind = dec_q.samp ? EV_NAK : EV_ACK;
                dec_d.evt.data = 8'h00;
                dec_d.cnt      = '0;
                dec_d.first    = 1'b0;
            end else begin
                dec_d.sh  = nxt_sh;
                dec_d.cnt = dec_q.cnt + 1'b1;
                if (dec_q.cnt == LAST_DBIT) begin
                    dec_d.push     = 1'b1;
                    dec_d.evt.data = nxt_sh;
                    if (!dec_q.first)
                        dec_d.evt.kind = EV_DATA;
                    else if (nxt_sh[7:3] == TEN_BIT_PREFIX)
                        dec_d.evt.kind = EV_ADDR10;
                    else
                        dec_d.evt.kind = EV_ADDR7;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q       <= '0;
            dec_q.scl_p <= 1'b1;
            dec_q.sda_p <= 1'b1;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign push_o = dec_q.push;
    assign evt_o  = dec_q.evt;

endmodule

// File: rtl/i2c_evt_fifo.sv
module i2c_evt_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 11,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          ready,
    output logic          valid,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] fill
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wr;
        logic [AW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } fq_t;

    fq_t  fq_d, fq_q;
    logic pop, acc;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        fq_d = fq_q;
        pop  = (fq_q.cnt != '0) && ready;
        acc  = push && ((fq_q.cnt != CW'(DEPTH)) || pop);
        if (acc) begin
            fq_d.mem[fq_q.wr] = din;
            fq_d.wr           = wrap_inc(fq_q.wr);
        end
        if (pop) fq_d.rd = wrap_inc(fq_q.rd);
        fq_d.cnt = fq_q.cnt + CW'(acc) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fq_q <= '0;
        else        fq_q <= fq_d;
    end

    assign valid = (fq_q.cnt != '0);
    assign dout  = fq_q.mem[fq_q.rd];
    assign fill  = fq_q.cnt;

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
    import i2c_mon_pkg::*;
#(
    parameter int unsigned FILT_LEN   = 3,
    parameter int unsigned FIFO_DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       evt_valid,
    input  logic       evt_ready,
    output logic [2:0] evt_type,
    output logic [7:0] evt_data
);

    localparam int unsigned EW = $bits(evt_t);
    localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);

    logic [1:0]    raw_lines;
    logic [1:0]    filt_lines;
    logic          scl_f, sda_f;
    logic          dec_push;
    evt_t          dec_evt;
    evt_t          head_evt;
    logic [CW-1:0] fill;

    assign raw_lines = {scl_i, sda_i};

    for (genvar gi = 0; gi < 2; gi++) begin : g_line
        i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_flt (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_in  (raw_lines[gi]),
            .line_out (filt_lines[gi])
        );
    end

    assign scl_f = filt_lines[1];
    assign sda_f = filt_lines[0];

    i2c_frame_decoder u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl    (scl_f),
        .sda    (sda_f),
        .push_o (dec_push),
        .evt_o  (dec_evt)
    );

    i2c_evt_fifo #(.DEPTH(FIFO_DEPTH), .W(EW), .CW(CW)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (dec_push),
        .din   (dec_evt),
        .ready (evt_ready),
        .valid (evt_valid),
        .dout  (head_evt),
        .fill  (fill)
    );

    assign evt_type = head_evt.kind;
    assign evt_data = head_evt.data;

endmodule

// File: rtl/i2c_mon_checker.sv
module i2c_mon_checker #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          evt_valid,
    input logic          evt_ready,
    input logic [2:0]    evt_type,
    input logic [7:0]    evt_data,
    input logic [CW-1:0] fill,
    input logic          scl_f,
    input logic          sda_f,
    input logic          dec_push,
    input logic [10:0]   dec_evt
);

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !evt_valid); // R1

    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_type) && $stable(evt_data))); // R11

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH)); // R11

    AST_COND_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_push && (dec_evt[10:8] <= 3'd2)) |-> ($past(scl_f) && $past(scl_f, 2))); // R12

    AST_EVENT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_push |-> (($past(scl_f) != $past(scl_f, 2)) || ($past(sda_f) != $past(sda_f, 2)))); // R8

endmodule

bind i2c_bus_monitor i2c_mon_checker #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_ready (evt_ready),
    .evt_type  (evt_type),
    .evt_data  (evt_data),
    .fill      (fill),
    .scl_f     (scl_f),
    .sda_f     (sda_f),
    .dec_push  (dec_push),
    .dec_evt   (dec_evt)
);

// File: tb/tb_i2c_bus_monitor.sv
module tb_i2c_bus_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int H          = 16;
    localparam int NVEC       = 6;
    // {first byte, second byte, ack bit 1, ack bit 2}
    localparam logic [17:0] VEC [NVEC] = '{
        {8'hA0, 8'h3C, 1'b0, 1'b0},
        {8'h91, 8'hFF, 1'b0, 1'b1},
        {8'hF2, 8'h55, 1'b0, 1'b0},
        {8'h4F, 8'h00, 1'b1, 1'b1},
        {8'hF7, 8'hA5, 1'b0, 1'b0},
        {8'hEF, 8'h81, 1'b0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       ready = 1'b1;
    logic       evt_valid;
    logic [2:0] evt_type;
    logic [7:0] evt_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [10:0] got [256];
    logic [10:0] ex  [64];
    int ng = 0;
    int rd = 0;
    int ne = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_bus_monitor dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda),
        .evt_valid (evt_valid),
        .evt_ready (ready),
        .evt_type  (evt_type),
        .evt_data  (evt_data)
    );

    always @(negedge clk) begin
        if (rst_n && evt_valid && ready) begin
            got[ng[7:0]] = {evt_type, evt_data};
            ng = ng + 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [10:0] act, input logic [10:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic put_bit(input logic b);
        sda = b; tick(H);
        scl = 1'b1; tick(H);
        scl = 1'b0; tick(H);
    endtask

    task automatic put_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
    endtask

    task automatic do_start;
        sda = 1'b0; tick(H);
        scl = 1'b0; tick(H);
    endtask

    task automatic do_restart;
        sda = 1'b1; tick(H);
        scl = 1'b1; tick(H);
        sda = 1'b0; tick(H);
        scl = 1'b0; tick(H);
    endtask

    task automatic do_stop;
        sda = 1'b0; tick(H);
        scl = 1'b1; tick(H);
        sda = 1'b1; tick(H);
    endtask

    task automatic exp_ev(input logic [2:0] t, input logic [7:0] v);
        ex[ne] = {t, v};
        ne++;
    endtask

    task automatic check_seq(input string tag);
        tick(60);
        chk((ng - rd) == ne, {tag, " event count"}, 11'(ng - rd), 11'(ne));
        for (int i = 0; i < ne; i++)
            chk(got[8'(rd + i)] === ex[i], tag, got[8'(rd + i)], ex[i]);
        rd = ng;
        ne = 0;
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1: nothing pending after reset
        chk(evt_valid == 1'b0, "R1 reset idle", 11'(evt_valid), 11'd0);

        // R2 R5 R6 R7 R12: table of complete transfers
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] b1, b2;
            logic a1, a2;
            {b1, b2, a1, a2} = VEC[v];
            do_start; put_byte(b1); put_bit(a1); put_byte(b2); put_bit(a2); do_stop;
            exp_ev(3'd0, 8'h00);
            exp_ev((b1[7:3] == 5'b11110) ? 3'd4 : 3'd3, b1);
            exp_ev(a1 ? 3'd7 : 3'd6, 8'h00);
            exp_ev(3'd5, b2);
            exp_ev(a2 ? 3'd7 : 3'd6, 8'h00);
            exp_ev(3'd2, 8'h00);
            check_seq("R2/R5/R6/R7/R12 table transfer");
        end

        // R3: repeated start after three committed bits
        do_start; put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        do_restart; put_byte(8'h42); put_bit(1'b0); do_stop;
        exp_ev(3'd0, 8'h00); exp_ev(3'd1, 8'h83); exp_ev(3'd3, 8'h42);
        exp_ev(3'd6, 8'h00); exp_ev(3'd2, 8'h00);
        check_seq("R3 restart mid-frame");

        // R3: repeated start on a frame boundary
        do_start; put_byte(8'hA0); put_bit(1'b0);
        do_restart; put_byte(8'hA1); put_bit(1'b1); do_stop;
        exp_ev(3'd0, 8'h00); exp_ev(3'd3, 8'hA0); exp_ev(3'd6, 8'h00);
        exp_ev(3'd1, 8'h00); exp_ev(3'd3, 8'hA1); exp_ev(3'd7, 8'h00);
        exp_ev(3'd2, 8'h00);
        check_seq("R3 restart at boundary");

        // R3: repeated start in place of the acknowledge slot
        do_start; put_byte(8'h44); do_restart; do_stop;
        exp_ev(3'd0, 8'h00); exp_ev(3'd3, 8'h44);
        exp_ev(3'd1, 8'h88); exp_ev(3'd2, 8'h00);
        check_seq("R3 restart before ack");

        // R4: stop after five bits
        do_start; for (int i = 0; i < 5; i++) put_bit(i[0]);
        do_stop;
        exp_ev(3'd0, 8'h00); exp_ev(3'd2, 8'h85);
        check_seq("R4 stop mid-frame");

        // R8: SCL held low for a long time mid-byte
        do_start;
        for (int i = 7; i >= 0; i--) begin
            put_bit(8'hC3 >> i);
            if (i == 4) tick(3000);
        end
        put_bit(1'b0); do_stop;
        exp_ev(3'd0, 8'h00); exp_ev(3'd3, 8'hC3);
        exp_ev(3'd6, 8'h00); exp_ev(3'd2, 8'h00);
        check_seq("R8 clock stretch");

        // R9: one-clock SCL spike while SCL is low inside a byte
        do_start;
        for (int i = 7; i >= 4; i--) put_bit(8'h5A >> i);
        scl = 1'b1; tick(1); scl = 1'b0; tick(H);
        for (int i = 3; i >= 0; i--) put_bit(8'h5A >> i);
        put_bit(1'b0); do_stop;
        exp_ev(3'd0, 8'h00); exp_ev(3'd3, 8'h5A);
        exp_ev(3'd6, 8'h00); exp_ev(3'd2, 8'h00);
        check_seq("R9 SCL spike");

        // R9: one-clock SDA dip with SCL high on an idle bus
        sda = 1'b0; tick(1); sda = 1'b1; tick(H);
        check_seq("R9 SDA spike");

        // R10: SCL toggling with no open transfer
        for (int i = 0; i < 5; i++) begin
            scl = 1'b0; tick(H); sda = i[0]; tick(H);
            sda = 1'b1; tick(H); scl = 1'b1; tick(H);
        end
        check_seq("R10 idle clocking");

        // R11: consumer stalls, then drains in order
        ready = 1'b0;
        do_start; put_byte(8'h3A); put_bit(1'b0); put_byte(8'hC5); put_bit(1'b1); do_stop;
        tick(60);
        chk(ng == rd, "R11 nothing taken while stalled", 11'(ng - rd), 11'd0);
        chk(evt_valid == 1'b1, "R11 valid held while stalled", 11'(evt_valid), 11'd1);
        ready = 1'b1;
        exp_ev(3'd0, 8'h00); exp_ev(3'd3, 8'h3A); exp_ev(3'd6, 8'h00);
        exp_ev(3'd5, 8'hC5); exp_ev(3'd7, 8'h00); exp_ev(3'd2, 8'h00);
        check_seq("R11 drain order");

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule